// File: doc/BRIEF.md
# CAN Receive Mailbox Matcher with Host Read Lock

This block sits behind a CAN receiver front end. Each time the front end reports a frame that arrived without errors, the block compares the frame's 11-bit identifier with every receive mailbox that is currently active. The frame is moved into the lowest-numbered matching mailbox. That mailbox then holds the identifier, the length code, eight data bytes and the 16-bit timestamp that the front end captured when the identifier field began. Its code is updated and its interrupt flag is raised. A move-in takes two clock edges. On the first edge the target mailbox shows a BUSY bit. On the second edge the mailbox contents and the code change together.

The host prepares a mailbox by writing its code and identifier. It reads a mailbox through an index-selected read port. A control/status read strobe locks the selected mailbox so that no incoming frame can overwrite it while the host reads the rest of it. A read of the free-running timer removes the lock. A control/status read of another mailbox moves the lock to that mailbox. Only one mailbox is locked at any time. A frame whose only match is the locked mailbox waits in a one-entry staging buffer and is written into that mailbox once the lock leaves it.

Top module: `canRxMailboxHub`

## Requirements
- R1: Matching happens only when `frmValid` is high. A mailbox takes part only if its code, with bit 0 ignored, is EMPTY (4'b0100), FULL (4'b0010) or OVERRUN (4'b0110), and only if its identifier equals `frmId` exactly. A mailbox with code 4'b0000 (inactive) never receives a frame.
- R2: Among the matching mailboxes that are not locked, the frame goes to the one with the lowest index.
- R3: On the edge that accepts a frame, bit 0 (BUSY) of the target mailbox's code is set. On the next edge the mailbox stores the identifier, length, data and timestamp, its code becomes FULL (4'b0010), and BUSY clears.
- R4: The target mailbox's `irqFlag` bit is set on the storing edge. Writing 1 to a bit of `flagClr` clears that flag bit. If a set and a clear happen on the same edge, the set wins.
- R5: A frame stored into a mailbox whose code was already FULL or OVERRUN leaves the code at OVERRUN (4'b0110).
- R6: A `rdCs` strobe locks mailbox `rdIdx` on the next edge, which sets `lockValid` and `lockIdx`. A `rdCs` to a different mailbox moves the lock to that mailbox.
- R7: A `tmrRd` strobe clears `lockValid` on the next edge. If `rdCs` is asserted on the same edge, `rdCs` takes priority.
- R8: A locked mailbox is never written. Its frame goes to the next matching mailbox that is not locked.
- R9: If the locked mailbox is the only match, the frame is staged. BUSY appears on the edge after the lock is cleared, and the frame is stored on the edge after that. A newer staged frame replaces an older one.
- R10: After reset, every mailbox code is 4'b0000, `irqFlag` is zero and `lockValid` is low.
- R11: `timerNow` increments by one on every clock edge.
- R12: A frame that matches no mailbox changes no code and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frmValid | input | 1 | An error-free frame is presented for one cycle |
| frmId | input | 11 | Received identifier |
| frmLen | input | 4 | Received length code |
| frmData | input | 64 | Eight received data bytes |
| frmStamp | input | 16 | Timer value captured at the start of the identifier |
| cfgWr | input | 1 | Host write of a mailbox code and identifier |
| cfgIdx | input | 4 | Mailbox selected for the host write |
| cfgCode | input | 4 | Code to write |
| cfgId | input | 11 | Identifier to write |
| rdIdx | input | 4 | Mailbox selected for reads |
| rdCs | input | 1 | Control/status read strobe; locks `rdIdx` |
| tmrRd | input | 1 | Timer read strobe; releases the lock |
| flagClr | input | 16 | Write-1-to-clear for the interrupt flags |
| rdCode | output | 4 | Code of the selected mailbox, with BUSY in bit 0 |
| rdId | output | 11 | Identifier of the selected mailbox |
| rdLen | output | 4 | Length of the selected mailbox |
| rdData | output | 64 | Data of the selected mailbox |
| rdStamp | output | 16 | Timestamp of the selected mailbox |
| timerNow | output | 16 | Free-running timer |
| irqFlag | output | 16 | Per-mailbox receive flags |
| lockValid | output | 1 | A mailbox is locked |
| lockIdx | output | 4 | Index of the locked mailbox |

## Verification
The bench builds the block with the package defaults: 16 mailboxes, 11-bit identifiers, a 4-bit length and a 16-bit timer. With these values it can place matches at index 0 and at index 15, the two ends of the priority search. The small mailbox count lets it build overlapping matches where the lowest match is inactive, locked or already full. It can also hold a frame in the staging buffer across a lock release, a lock move and a replacement by a newer frame.

// File: rtl/canRxPkg.sv
`timescale 1ns/1ps
package canRxPkg;
  parameter int unsigned NUM_MB = 16;
  parameter int unsigned ID_W   = 11;
  parameter int unsigned TS_W   = 16;
  parameter int unsigned LEN_W  = 4;
  parameter int unsigned BYTES  = 8;
  localparam int unsigned DATA_W = BYTES * 8;
  localparam int unsigned IDX_W  = $clog2(NUM_MB);

  typedef logic [3:0] codeT;
  localparam codeT CODE_OFF   = 4'b0000;
  localparam codeT CODE_EMPTY = 4'b0100;
  localparam codeT CODE_FULL  = 4'b0010;
  localparam codeT CODE_OVR   = 4'b0110;
  localparam codeT BUSY_MASK  = 4'b0001;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
    logic [TS_W-1:0]   stamp;
  } frameT;

  // strobes from control to datapath
  typedef struct packed {
    logic             setBusy;
    logic [IDX_W-1:0] busyIdx;
    logic             commit;
    logic [IDX_W-1:0] commitIdx;
    frameT            frame;
  } stbT;
endpackage

// File: rtl/canRxCtrl.sv
`timescale 1ns/1ps
module canRxCtrl import canRxPkg::*; (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frmValid,
  input  frameT                      frmIn,
  input  logic [NUM_MB-1:0][3:0]     codeAll,
  input  logic [NUM_MB-1:0][ID_W-1:0] idAll,
  input  logic                       rdCs,
  input  logic [IDX_W-1:0]           rdIdx,
  input  logic                       tmrRd,
  output stbT                        stb,
  output logic                       lockValid,
  output logic [IDX_W-1:0]           lockIdx
);
  logic [NUM_MB-1:0] matchVec, lockMask, freeVec;
  logic              freeHit, acceptNow, stageNow, drainNow;
  logic [IDX_W-1:0]  freeIdx;
  logic              stgValid, mvValid;
  logic [IDX_W-1:0]  stgIdx, mvIdx;
  frameT             stgFrame, mvFrame;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_match
    logic [3:0] baseCode;
    assign baseCode = codeAll[i] & ~BUSY_MASK;
    assign matchVec[i] = ((baseCode == CODE_EMPTY) || (baseCode == CODE_FULL) ||
                          (baseCode == CODE_OVR)) && (idAll[i] == frmIn.id);
  end

  always_comb begin
    lockMask = '0;
    if (lockValid) lockMask[lockIdx] = 1'b1;
    freeVec = matchVec & ~lockMask;
    freeHit = 1'b0;
    freeIdx = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        freeHit = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign acceptNow = frmValid && freeHit;
  assign stageNow  = frmValid && !freeHit && (|matchVec);
  assign drainNow  = stgValid && !acceptNow && !(lockValid && (lockIdx == stgIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockValid <= 1'b0;
      lockIdx   <= '0;
      stgValid  <= 1'b0;
      stgIdx    <= '0;
      stgFrame  <= '0;
      mvValid   <= 1'b0;
      mvIdx     <= '0;
      mvFrame   <= '0;
    end else begin
      if (rdCs) begin
        lockValid <= 1'b1;
        lockIdx   <= rdIdx;
      end else if (tmrRd) begin
        lockValid <= 1'b0;
      end
      if (stageNow) begin
        stgValid <= 1'b1;
        stgIdx   <= lockIdx;
        stgFrame <= frmIn;
      end else if (drainNow) begin
        stgValid <= 1'b0;
      end
      mvValid <= acceptNow || drainNow;
      if (acceptNow) begin
        mvIdx   <= freeIdx;
        mvFrame <= frmIn;
      end else if (drainNow) begin
        mvIdx   <= stgIdx;
        mvFrame <= stgFrame;
      end
    end
  end

  always_comb begin
    stb.setBusy   = acceptNow || drainNow;
    stb.busyIdx   = acceptNow ? freeIdx : stgIdx;
    stb.commit    = mvValid;
    stb.commitIdx = mvIdx;
    stb.frame     = mvFrame;
  end
endmodule

// File: rtl/canRxStore.sv
`timescale 1ns/1ps
module canRxStore import canRxPkg::*; (
  input  logic                        clk,
  input  logic                        rstN,
  input  stbT                         stb,
  input  logic                        cfgWr,
  input  logic [IDX_W-1:0]            cfgIdx,
  input  logic [3:0]                  cfgCode,
  input  logic [ID_W-1:0]             cfgId,
  input  logic [NUM_MB-1:0]           flagClr,
  input  logic [IDX_W-1:0]            rdIdx,
  output logic [NUM_MB-1:0][3:0]      codeAll,
  output logic [NUM_MB-1:0][ID_W-1:0] idAll,
  output logic [3:0]                  rdCode,
  output logic [ID_W-1:0]             rdId,
  output logic [LEN_W-1:0]            rdLen,
  output logic [DATA_W-1:0]           rdData,
  output logic [TS_W-1:0]             rdStamp,
  output logic [TS_W-1:0]             timerNow,
  output logic [NUM_MB-1:0]           irqFlag
);
  logic [NUM_MB-1:0][LEN_W-1:0]  lenAll;
  logic [NUM_MB-1:0][DATA_W-1:0] dataAll;
  logic [NUM_MB-1:0][TS_W-1:0]   stampAll;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic [3:0] codeR;
    logic       busyR;
    logic       hitCfg, hitCommit, hitBusy;
    assign hitCfg    = cfgWr && (cfgIdx == IDX_W'(i));
    assign hitCommit = stb.commit && (stb.commitIdx == IDX_W'(i));
    assign hitBusy   = stb.setBusy && (stb.busyIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeR       <= CODE_OFF;
        busyR       <= 1'b0;
        irqFlag[i]  <= 1'b0;
        idAll[i]    <= '0;
        lenAll[i]   <= '0;
        dataAll[i]  <= '0;
        stampAll[i] <= '0;
      end else begin
        if (hitCfg) begin
          codeR    <= cfgCode;
          idAll[i] <= cfgId;
        end
        if (hitCommit) begin
          codeR       <= ((codeR == CODE_FULL) || (codeR == CODE_OVR)) ? CODE_OVR : CODE_FULL;
          idAll[i]    <= stb.frame.id;
          lenAll[i]   <= stb.frame.len;
          dataAll[i]  <= stb.frame.data;
          stampAll[i] <= stb.frame.stamp;
          busyR       <= 1'b0;
        end
        if (hitBusy) busyR <= 1'b1;
        if (hitCommit) irqFlag[i] <= 1'b1;
        else if (flagClr[i]) irqFlag[i] <= 1'b0;
      end
    end
    assign codeAll[i] = codeR | (busyR ? BUSY_MASK : CODE_OFF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerNow <= '0;
    else       timerNow <= timerNow + 1'b1;
  end

  assign rdCode  = codeAll[rdIdx];
  assign rdId    = idAll[rdIdx];
  assign rdLen   = lenAll[rdIdx];
  assign rdData  = dataAll[rdIdx];
  assign rdStamp = stampAll[rdIdx];
endmodule

// File: rtl/canRxMailboxHub.sv
`timescale 1ns/1ps
module canRxMailboxHub import canRxPkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic [ID_W-1:0]   frmId,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic [DATA_W-1:0] frmData,
  input  logic [TS_W-1:0]   frmStamp,
  input  logic              cfgWr,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [3:0]        cfgCode,
  input  logic [ID_W-1:0]   cfgId,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              rdCs,
  input  logic              tmrRd,
  input  logic [NUM_MB-1:0] flagClr,
  output logic [3:0]        rdCode,
  output logic [ID_W-1:0]   rdId,
  output logic [LEN_W-1:0]  rdLen,
  output logic [DATA_W-1:0] rdData,
  output logic [TS_W-1:0]   rdStamp,
  output logic [TS_W-1:0]   timerNow,
  output logic [NUM_MB-1:0] irqFlag,
  output logic              lockValid,
  output logic [IDX_W-1:0]  lockIdx
);
  frameT                       frmIn;
  stbT                         stb;
  logic [NUM_MB-1:0][3:0]      mbCodeAll;
  logic [NUM_MB-1:0][ID_W-1:0] mbIdAll;

  assign frmIn = '{id: frmId, len: frmLen, data: frmData, stamp: frmStamp};

  canRxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmIn(frmIn),
    .codeAll(mbCodeAll), .idAll(mbIdAll), .rdCs(rdCs), .rdIdx(rdIdx),
    .tmrRd(tmrRd), .stb(stb), .lockValid(lockValid), .lockIdx(lockIdx)
  );

  canRxStore u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWr(cfgWr), .cfgIdx(cfgIdx),
    .cfgCode(cfgCode), .cfgId(cfgId), .flagClr(flagClr), .rdIdx(rdIdx),
    .codeAll(mbCodeAll), .idAll(mbIdAll), .rdCode(rdCode), .rdId(rdId),
    .rdLen(rdLen), .rdData(rdData), .rdStamp(rdStamp), .timerNow(timerNow),
    .irqFlag(irqFlag)
  );
endmodule

// File: rtl/canRxMailboxChk.sv
`timescale 1ns/1ps
module canRxMailboxChk import canRxPkg::*; (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rdCs,
  input logic                   tmrRd,
  input logic [IDX_W-1:0]       rdIdx,
  input logic                   lockValid,
  input logic [IDX_W-1:0]       lockIdx,
  input logic [NUM_MB-1:0]      irqFlag,
  input logic                   setBusy,
  input logic [IDX_W-1:0]       busyIdx,
  input logic                   commit,
  input logic [IDX_W-1:0]       commitIdx,
  input logic [NUM_MB-1:0][3:0] mbCodeAll
);
  logic [NUM_MB-1:0] busyBits;
  always_comb for (int i = 0; i < NUM_MB; i++) busyBits[i] = mbCodeAll[i][0];

  p_lock_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdCs |=> lockValid && (lockIdx == $past(rdIdx)));

  p_lock_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tmrRd && !rdCs) |=> !lockValid);

  p_locked_safe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lockValid && setBusy) |-> (busyIdx != lockIdx));

  p_busy_to_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    setBusy |=> commit && (commitIdx == $past(busyIdx)));

  p_one_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busyBits));

  p_store_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> ((mbCodeAll[$past(commitIdx)][3:1] == 3'b001) ||
                (mbCodeAll[$past(commitIdx)][3:1] == 3'b011)) &&
               irqFlag[$past(commitIdx)]);
endmodule

bind canRxMailboxHub canRxMailboxChk u_chk (
  .clk(clk), .rstN(rstN), .rdCs(rdCs), .tmrRd(tmrRd), .rdIdx(rdIdx),
  .lockValid(lockValid), .lockIdx(lockIdx), .irqFlag(irqFlag),
  .setBusy(stb.setBusy), .busyIdx(stb.busyIdx), .commit(stb.commit),
  .commitIdx(stb.commitIdx), .mbCodeAll(mbCodeAll)
);

// File: tb/test_canRxMailboxHub.sv
`timescale 1ns/1ps
module test_canRxMailboxHub;
  localparam logic [3:0] C_OFF = 4'b0000, C_EMPTY = 4'b0100, C_FULL = 4'b0010,
                         C_OVR = 4'b0110, C_BUSY = 4'b0001;

  logic clk = 1'b0, rstN = 1'b0;
  logic frmValid = 0; logic [10:0] frmId = '0; logic [3:0] frmLen = '0;
  logic [63:0] frmData = '0; logic [15:0] frmStamp = '0;
  logic cfgWr = 0; logic [3:0] cfgIdx = '0, cfgCode = '0; logic [10:0] cfgId = '0;
  logic [3:0] rdIdx = '0; logic rdCs = 0, tmrRd = 0; logic [15:0] flagClr = '0;
  logic [3:0] rdCode, rdLen, lockIdx; logic [10:0] rdId; logic [63:0] rdData;
  logic [15:0] rdStamp, timerNow, irqFlag; logic lockValid;

  canRxMailboxHub i_canRxMailboxHub (.*);

  always #2 clk = ~clk;

  typedef struct { int mb; logic [3:0] code; logic [10:0] id; logic [3:0] len;
                   logic [63:0] data; logic [15:0] stamp; } expT;
  expT expQ[$];
  int  obsQ[$];
  int  nRun = 0, nFail = 0;
  bit  finished = 0;
  logic [15:0] prevFlag = '0;

  // monitor: records each mailbox whose flag rises
  always @(negedge clk) begin
    if (rstN)
      for (int i = 0; i < 16; i++) if (irqFlag[i] && !prevFlag[i]) obsQ.push_back(i);
    prevFlag = irqFlag;
  end

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic readMb(input int idx);
    rdIdx = idx[3:0];
    #0.2;
  endtask

  task automatic cfgMb(input int idx, input logic [3:0] code, input logic [10:0] id);
    @(negedge clk);
    cfgWr = 1; cfgIdx = idx[3:0]; cfgCode = code; cfgId = id;
    @(negedge clk);
    cfgWr = 0;
  endtask

  // drives one frame; returns just after the accepting edge
  task automatic sendFrame(input logic [10:0] id, input logic [3:0] len,
                           input logic [63:0] data, input logic [15:0] stamp);
    @(negedge clk);
    frmValid = 1; frmId = id; frmLen = len; frmData = data; frmStamp = stamp;
    @(negedge clk);
    frmValid = 0;
  endtask

  task automatic expectMb(input int mb, input logic [3:0] code, input logic [10:0] id,
                          input logic [3:0] len, input logic [63:0] data, input logic [15:0] stamp);
    expT e;
    e.mb = mb; e.code = code; e.id = id; e.len = len; e.data = data; e.stamp = stamp;
    expQ.push_back(e);
  endtask

  task automatic pulseRd(input bit cs, input bit tmr, input int idx);
    @(negedge clk);
    rdCs = cs; tmrRd = tmr; rdIdx = idx[3:0];
    @(negedge clk);
    rdCs = 0; tmrRd = 0;
  endtask

  task automatic clearFlags();
    @(negedge clk);
    flagClr = '1;
    @(negedge clk);
    flagClr = '0;
  endtask

  // scoreboard: pair oldest expectation with oldest observed delivery
  task automatic scoreCheck(input string tag);
    expT e;
    #0.5;
    e = expQ.pop_front();
    chkEq({tag, " delivery count"}, obsQ.size(), 1);
    if (obsQ.size() > 0) chkEq({tag, " mailbox"}, obsQ.pop_front(), e.mb);
    obsQ.delete();
    readMb(e.mb);
    chkEq({tag, " code"}, rdCode, e.code);
    chkEq({tag, " id"}, rdId, e.id);
    chkEq({tag, " len"}, rdLen, e.len);
    chkEq({tag, " data"}, rdData, e.data);
    chkEq({tag, " stamp"}, rdStamp, e.stamp);
    clearFlags();
  endtask

  initial begin
    #(4 * 50000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] t0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 reset state
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); readMb(i);
      chkEq($sformatf("R10 code mb%0d", i), rdCode, C_OFF);
    end
    chkEq("R10 flags", irqFlag, 0);
    chkEq("R10 lock", lockValid, 0);

    // R11 timer
    @(negedge clk); t0 = timerNow;
    repeat (5) @(negedge clk);
    chkEq("R11 timer step", timerNow - t0, 5);

    cfgMb(0, C_OFF, 11'h123);
    cfgMb(2, C_EMPTY, 11'h123);
    cfgMb(5, C_EMPTY, 11'h123);
    cfgMb(7, C_EMPTY, 11'h055);
    cfgMb(15, C_EMPTY, 11'h7FF);

    // R1 R2 R3: lowest active match, busy then store
    sendFrame(11'h123, 4'd8, 64'h1122334455667788, 16'h0A0A);
    readMb(2); chkEq("R3 busy on accept", rdCode, C_EMPTY | C_BUSY);
    readMb(5); chkEq("R2 higher match untouched", rdCode, C_EMPTY);
    expectMb(2, C_FULL, 11'h123, 4'd8, 64'h1122334455667788, 16'h0A0A);
    @(negedge clk); scoreCheck("R1 R2 R3 move-in");

    // R5 overrun
    sendFrame(11'h123, 4'd3, 64'hCAFE, 16'h0B0B);
    readMb(2); chkEq("R3 busy over full", rdCode, C_FULL | C_BUSY);
    expectMb(2, C_OVR, 11'h123, 4'd3, 64'hCAFE, 16'h0B0B);
    @(negedge clk); scoreCheck("R5 overrun");

    // top index
    sendFrame(11'h7FF, 4'd15, 64'hFFEE, 16'h0C0C);
    expectMb(15, C_FULL, 11'h7FF, 4'd15, 64'hFFEE, 16'h0C0C);
    @(negedge clk); scoreCheck("R1 mailbox 15");

    // R12 no match
    sendFrame(11'h400, 4'd1, 64'h1, 16'h1);
    repeat (2) @(negedge clk); #0.5;
    chkEq("R12 no flag", irqFlag, 0);
    chkEq("R12 no delivery", obsQ.size(), 0);
    readMb(7); chkEq("R12 mb7 code", rdCode, C_EMPTY);

    // R6 lock, R8 divert
    pulseRd(1, 0, 2);
    chkEq("R6 lock valid", lockValid, 1);
    chkEq("R6 lock idx", lockIdx, 2);
    sendFrame(11'h123, 4'd2, 64'hBEEF, 16'h0D0D);
    expectMb(5, C_FULL, 11'h123, 4'd2, 64'hBEEF, 16'h0D0D);
    @(negedge clk); scoreCheck("R8 divert");
    readMb(2);
    chkEq("R8 locked code", rdCode, C_OVR);
    chkEq("R8 locked data", rdData, 64'hCAFE);

    pulseRd(1, 0, 7);
    chkEq("R6 lock moved", lockIdx, 7);
    pulseRd(0, 1, 7);
    chkEq("R7 released", lockValid, 0);

    // R9 staging behind the lock on the only match
    pulseRd(1, 0, 15);
    sendFrame(11'h7FF, 4'd4, 64'hAAAA, 16'h0E0E);
    repeat (2) @(negedge clk);
    readMb(15);
    chkEq("R9 held code", rdCode, C_FULL);
    chkEq("R9 held data", rdData, 64'hFFEE);
    sendFrame(11'h7FF, 4'd5, 64'hBBBB, 16'h0F0F);
    @(negedge clk);
    tmrRd = 1;
    @(negedge clk);
    tmrRd = 0;
    readMb(15); chkEq("R9 not busy at release", rdCode, C_FULL);
    @(negedge clk);
    readMb(15); chkEq("R9 busy after release", rdCode, C_FULL | C_BUSY);
    expectMb(15, C_OVR, 11'h7FF, 4'd5, 64'hBBBB, 16'h0F0F);
    @(negedge clk); scoreCheck("R9 staged newest");

    // R4 set wins over clear
    sendFrame(11'h055, 4'd6, 64'h5555, 16'h1010);
    flagClr = '1;
    @(negedge clk);
    flagClr = '0;
    #0.5;
    chkEq("R4 set wins", irqFlag[7], 1);
    expectMb(7, C_FULL, 11'h055, 4'd6, 64'h5555, 16'h1010);
    scoreCheck("R4 delivery");
    chkEq("R4 cleared", irqFlag, 0);

    // R7 rdCs priority over tmrRd
    pulseRd(1, 1, 3);
    chkEq("R7 cs wins valid", lockValid, 1);
    chkEq("R7 cs wins idx", lockIdx, 3);
    pulseRd(0, 1, 3);

    // R1 inactive mailboxes ignored
    cfgMb(2, C_OFF, 11'h123);
    cfgMb(5, C_OFF, 11'h123);
    sendFrame(11'h123, 4'd1, 64'h9, 16'h9);
    repeat (2) @(negedge clk); #0.5;
    chkEq("R1 inactive flags", irqFlag, 0);
    readMb(2); chkEq("R1 inactive code", rdCode, C_OFF);
    readMb(0); chkEq("R1 mb0 code", rdCode, C_OFF);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule